// File: doc/BRIEF.md
# Two-Level Routing Selector with Grounded Input

This block is the configurable selector placed wherever a programmable fabric must pick one net out of several. Examples are the inputs of a logic element, a connection block, or a switch-block output. It takes `N_IN` data inputs and adds one more input that is tied to logic 0 inside the block. When the selector is left unused, that grounded input is chosen, so the output acts as a constant-zero source.

The selection is held in a configuration word. The word is loaded one bit per clock through a serial shift chain, and a serial output lets several selectors be linked into one longer chain. The default build splits the selection into two ranks:

- A first rank of equal primitives, each 2, 3 or 4 inputs wide, all sharing one one-hot select field.
- A second-rank primitive that picks one first-rank output with its own one-hot field.

A build parameter replaces the two ranks with a binary tree of 2-input selectors, steered by a binary index. Any select word that does not name a real data input gives an output of 0.

Top module: `rmux_top`

## Requirements
- R1: While `rst` is high, at each rising clock edge the configuration word takes a default value that selects the grounded input. `mux_out` is then 0 whatever `data_in` carries.
- R2: At each rising edge where `cfg_en` is high, the configuration word shifts by one place toward its MSB, and `cfg_in` enters at bit 0. `cfg_out` always shows the current MSB. A word shifted in MSB-first is therefore complete after `CFG_W` enabled edges.
- R3: At any rising edge where `cfg_en` is low, the configuration word is unchanged, whatever `cfg_in` does.
- R4: In the two-rank build, bits [P-1:0] of the word are the first-rank one-hot field and bits [P+G-1:P] are the second-rank one-hot field. First-rank bit k together with second-rank bit g routes `data_in[g*P+k]` to `mux_out`, combinationally.
- R5: Slots g*P+k that are at or above `N_IN` carry 0. The grounded input is the last slot of the last first-rank primitive (slot G*P-1). In the tree build the grounded input is the last leaf, index 2^S-1.
- R6: In the two-rank build, if either one-hot field has no bit set or more than one bit set, `mux_out` is 0.
- R7: The primitive width P is the smallest of 2, 3, 4 for which G = ceil((N_IN+1)/P) is at most 4, and `CFG_W` = P+G. For N_IN=10 this gives P=3, G=4, CFG_W=7, and a default word of 7'b1000100.
- R8: With `TREE_MODE` set, the word is an S = clog2(N_IN+1) bit binary index. `mux_out` is `data_in[index]` for an index below `N_IN` and 0 otherwise. The default index is 2^S-1. For N_IN=10 this gives CFG_W=4 and a default of 4'b1111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration chain |
| rst | input | 1 | Synchronous active-high reset to the grounded selection |
| cfg_en | input | 1 | Shift enable for the configuration chain |
| cfg_in | input | 1 | Serial configuration bit entering bit 0 |
| data_in | input | N_IN | Data inputs to be selected |
| mux_out | output | 1 | Selected data, or 0 |
| cfg_out | output | 1 | MSB of the configuration word, for chaining |

## Verification
The properties assume that `rst`, `cfg_en` and `cfg_in` are free of X and change only between clock edges. They also assume `data_in` is a known value whenever the output is sampled, because the data path itself has no clock. The stimulus drives every input one time unit after a rising edge and compares outputs on the falling edge, which keeps all changes clear of the sampling edge. Illegal select words are produced only by shifting them in through the normal chain, never by forcing internal state.

// File: rtl/rmux_pkg.sv
package rmux_pkg;

    localparam int MAX_SECOND = 4;

    typedef enum logic {
        BUILD_TWO_RANK = 1'b0,
        BUILD_TREE     = 1'b1
    } build_e;

    function automatic int prim_width(input int n_tot);
        for (int p = 2; p <= 4; p++) begin
            if ((n_tot + p - 1) / p <= MAX_SECOND) return p;
        end
        return 4;
    endfunction

    function automatic int group_count(input int n_tot);
        int p;
        p = prim_width(n_tot);
        return (n_tot + p - 1) / p;
    endfunction

    function automatic int index_bits(input int n_tot);
        return $clog2(n_tot);
    endfunction

    function automatic int word_width(input int n_in, input bit tree);
        if (tree) return index_bits(n_in + 1);
        return prim_width(n_in + 1) + group_count(n_in + 1);
    endfunction

    function automatic int unsigned default_word(input int n_in, input bit tree);
        int p;
        int g;
        if (tree) return (32'd1 << index_bits(n_in + 1)) - 32'd1;
        p = prim_width(n_in + 1);
        g = group_count(n_in + 1);
        return (32'd1 << (p + g - 1)) | (32'd1 << (p - 1));
    endfunction

endpackage

// File: rtl/rmux_cfg_chain.sv
module rmux_cfg_chain #(
    parameter int          W        = 7,
    parameter logic [W-1:0] RST_WORD = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         ser_in,
    output logic [W-1:0] word,
    output logic         ser_out
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word <= RST_WORD;
        end else if (shift_en) begin
            word <= {word[W-2:0], ser_in};
        end
    end

    assign ser_out = word[W-1];
endmodule

// File: rtl/rmux_prim.sv
module rmux_prim #(
    parameter int N = 3
) (
    input  logic [N-1:0] sel,
    input  logic [N-1:0] din,
    output logic         dout
);
    logic [$clog2(N+1)-1:0] ones;
    logic                   legal;

    always_comb begin
        ones = '0;
        for (int i = 0; i < N; i++) begin
            ones = ones + {{($clog2(N+1)-1){1'b0}}, sel[i]};
        end
    end

    assign legal = (ones == 1);
    assign dout  = legal & (|(sel & din));
endmodule

// File: rtl/rmux_two_rank.sv
module rmux_two_rank #(
    parameter int N_IN = 10,
    parameter int P    = 3,
    parameter int G    = 4
) (
    input  logic [N_IN-1:0] din,
    input  logic [P-1:0]    sel_first,
    input  logic [G-1:0]    sel_second,
    output logic            dout
);
    localparam int SLOTS = G * P;
    localparam int PAD   = SLOTS - N_IN;

    logic [SLOTS-1:0] slots;
    logic [G-1:0]     rank_out;

    // top slot is the grounded input; other spare slots are also tied low
    assign slots = {{PAD{1'b0}}, din};

    for (genvar g = 0; g < G; g++) begin : gen_first
        rmux_prim #(.N(P)) u_prim (
            .sel  (sel_first),
            .din  (slots[g*P +: P]),
            .dout (rank_out[g])
        );
    end

    rmux_prim #(.N(G)) u_second (
        .sel  (sel_second),
        .din  (rank_out),
        .dout (dout)
    );
endmodule

// File: rtl/rmux_tree.sv
module rmux_tree #(
    parameter int N_IN = 10,
    parameter int S    = 4
) (
    input  logic [N_IN-1:0] din,
    input  logic [S-1:0]    idx,
    output logic            dout
);
    localparam int LEAVES = 1 << S;
    localparam int PAD    = LEAVES - N_IN;

    for (genvar l = 0; l <= S; l++) begin : gen_lvl
        logic [(LEAVES >> l)-1:0] node;
        if (l == 0) begin : g_leaf
            assign node = {{PAD{1'b0}}, din};
        end else begin : g_inner
            for (genvar j = 0; j < (LEAVES >> l); j++) begin : gen_node
                assign node[j] = idx[l-1] ? gen_lvl[l-1].node[2*j+1]
                                          : gen_lvl[l-1].node[2*j];
            end
        end
    end

    assign dout = gen_lvl[S].node[0];
endmodule

// File: rtl/rmux_top.sv
module rmux_top #(
    parameter int N_IN      = 10,
    parameter bit TREE_MODE = 1'b0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_en,
    input  logic            cfg_in,
    input  logic [N_IN-1:0] data_in,
    output logic            mux_out,
    output logic            cfg_out
);
    import rmux_pkg::*;

    localparam build_e       BUILD  = TREE_MODE ? BUILD_TREE : BUILD_TWO_RANK;
    localparam int           N_TOT  = N_IN + 1;
    localparam int           P      = prim_width(N_TOT);
    localparam int           G      = group_count(N_TOT);
    localparam int           S      = index_bits(N_TOT);
    localparam int           CFG_W  = word_width(N_IN, TREE_MODE);
    localparam logic [CFG_W-1:0] RST_WORD = CFG_W'(default_word(N_IN, TREE_MODE));

    logic [CFG_W-1:0] cfg_word;

    rmux_cfg_chain #(.W(CFG_W), .RST_WORD(RST_WORD)) u_chain (
        .clk      (clk),
        .rst      (rst),
        .shift_en (cfg_en),
        .ser_in   (cfg_in),
        .word     (cfg_word),
        .ser_out  (cfg_out)
    );

    if (BUILD == BUILD_TREE) begin : g_tree
        rmux_tree #(.N_IN(N_IN), .S(S)) u_sel (
            .din  (data_in),
            .idx  (cfg_word),
            .dout (mux_out)
        );
    end else begin : g_two
        rmux_two_rank #(.N_IN(N_IN), .P(P), .G(G)) u_sel (
            .din        (data_in),
            .sel_first  (cfg_word[P-1:0]),
            .sel_second (cfg_word[P+G-1:P]),
            .dout       (mux_out)
        );
    end
endmodule

// File: rtl/rmux_checker.sv
module rmux_checker #(
    parameter int N_IN      = 10,
    parameter bit TREE_MODE = 1'b0,
    parameter int CFG_W     = 7,
    parameter int P         = 3,
    parameter int G         = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_en,
    input logic             mux_out,
    input logic             cfg_out,
    input logic [CFG_W-1:0] cfg_q
);
    // R1: first cycle out of reset drives the grounded input
    a_r1_reset_ground: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (mux_out == 1'b0));

    // R2: serial output advances by one stage per enabled edge
    a_r2_chain_step: assert property (@(posedge clk) disable iff (rst)
        cfg_en |=> (cfg_out == $past(cfg_q[CFG_W-2])));

    // R3: word frozen while not shifting
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |=> $stable(cfg_q));

    if (TREE_MODE) begin : g_tree_chk
        // R5 R8: index past the data inputs yields 0
        a_r8_spare_zero: assert property (@(posedge clk) disable iff (rst)
            (int'(cfg_q) >= N_IN) |-> (mux_out == 1'b0));
    end else begin : g_two_chk
        // R6: illegal one-hot field forces 0
        a_r6_first_bad: assert property (@(posedge clk) disable iff (rst)
            ($countones(cfg_q[P-1:0]) != 1) |-> (mux_out == 1'b0));
        a_r6_second_bad: assert property (@(posedge clk) disable iff (rst)
            ($countones(cfg_q[P+G-1:P]) != 1) |-> (mux_out == 1'b0));
        // R5: grounded slot selected gives 0
        a_r5_ground: assert property (@(posedge clk) disable iff (rst)
            (cfg_q[P-1] && cfg_q[P+G-1]) |-> (mux_out == 1'b0));
    end
endmodule

bind rmux_top rmux_checker #(
    .N_IN(N_IN), .TREE_MODE(TREE_MODE), .CFG_W(CFG_W), .P(P), .G(G)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cfg_en  (cfg_en),
    .mux_out (mux_out),
    .cfg_out (cfg_out),
    .cfg_q   (cfg_word)
);

// File: tb/rmux_top_tb.sv
module rmux_top_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en_a = 1'b0, in_a = 1'b0, en_b = 1'b0, in_b = 1'b0;
    logic [9:0] data = '0;
    logic       out_a, cout_a, out_b, cout_b;
    int         checks = 0;
    int         failures = 0;
    bit         done = 1'b0;

    typedef struct {
        int    kind;   // 0 two-rank out, 1 tree out, 2 two-rank cfg_out, 3 tree cfg_out
        logic  exp;
        string req;
    } item_t;
    item_t sb[$];

    always #2.5 clk = ~clk;

    rmux_top #(.N_IN(10), .TREE_MODE(1'b0)) u_dut (
        .clk(clk), .rst(rst), .cfg_en(en_a), .cfg_in(in_a),
        .data_in(data), .mux_out(out_a), .cfg_out(cout_a));

    rmux_top #(.N_IN(10), .TREE_MODE(1'b1)) u_dut_tree (
        .clk(clk), .rst(rst), .cfg_en(en_b), .cfg_in(in_b),
        .data_in(data), .mux_out(out_b), .cfg_out(cout_b));

    function automatic logic model_two(input logic [6:0] w, input logic [9:0] d);
        int k = 0;
        int g = 0;
        int idx;
        if ($countones(w[2:0]) != 1 || $countones(w[6:3]) != 1) return 1'b0;
        for (int i = 0; i < 3; i++) if (w[i]) k = i;
        for (int i = 0; i < 4; i++) if (w[3+i]) g = i;
        idx = g * 3 + k;
        return (idx < 10) ? d[idx] : 1'b0;
    endfunction

    function automatic logic model_tree(input logic [3:0] w, input logic [9:0] d);
        return (int'(w) < 10) ? d[w] : 1'b0;
    endfunction

    // monitor: compare every queued expectation on the falling edge
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            logic  act;
            it = sb.pop_front();
            case (it.kind)
                0: act = out_a;
                1: act = out_b;
                2: act = cout_a;
                default: act = cout_b;
            endcase
            checks++;
            if (act !== it.exp) begin
                failures++;
                $display("FAIL %s kind=%0d actual=%b expected=%b", it.req, it.kind, act, it.exp);
            end
        end
    end

    task automatic expect_now(input int kind, input logic e, input string req);
        item_t it;
        it.kind = kind; it.exp = e; it.req = req;
        sb.push_back(it);
        @(posedge clk); #1;
    endtask

    task automatic load_two(input logic [6:0] w);
        for (int i = 6; i >= 0; i--) begin
            en_a = 1'b1; in_a = w[i];
            @(posedge clk); #1;
        end
        en_a = 1'b0;
    endtask

    task automatic load_tree(input logic [3:0] w);
        for (int i = 3; i >= 0; i--) begin
            en_b = 1'b1; in_b = w[i];
            @(posedge clk); #1;
        end
        en_b = 1'b0;
    endtask

    task automatic apply_two(input logic [6:0] w, input logic [9:0] d, input string req);
        load_two(w);
        data = d;
        expect_now(0, model_two(w, d), req);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        data = '1;
        rst  = 1'b0;
        // R1: default word selects ground in both builds
        expect_now(0, 1'b0, "R1");
        expect_now(1, 1'b0, "R1 R8");
        // R2 R7: default word 1000100 puts 1 on the serial output; tree default 1111
        expect_now(2, 1'b1, "R2 R7");
        expect_now(3, 1'b1, "R2 R8");
        // R2: one enabled edge moves old bit 5 (0) to the MSB
        en_a = 1'b1; in_a = 1'b0;
        @(posedge clk); #1;
        en_a = 1'b0;
        expect_now(2, 1'b0, "R2");

        // R4 R7: walk every data input through its group/position
        for (int i = 0; i < 10; i++) begin
            logic [6:0] w;
            w = 7'((1 << (3 + i / 3)) | (1 << (i % 3)));
            apply_two(w, 10'(1 << i), "R4 R7");
            data = ~10'(1 << i);
            expect_now(0, 1'b0, "R4");
        end

        // R5: grounded slot and spare slot give 0 with all data high
        apply_two(7'b1000100, '1, "R5");
        apply_two(7'b1000010, '1, "R5");

        // R6: illegal fields
        apply_two(7'b0000000, '1, "R6");
        apply_two(7'b0001011, '1, "R6");
        apply_two(7'b0110001, '1, "R6");
        apply_two(7'b0010000, '1, "R6");

        // R3: select input 4, then toggle cfg_in with enable low
        apply_two(7'b0010010, 10'(1 << 4), "R3");
        for (int c = 0; c < 6; c++) begin
            in_a = c[0];
            data = (c % 2 == 0) ? 10'(1 << 4) : ~10'(1 << 4);
            expect_now(0, (c % 2 == 0) ? 1'b1 : 1'b0, "R3");
        end
        expect_now(2, 1'b0, "R3");

        // R8: tree build, every index with two data patterns
        for (int x = 0; x < 16; x++) begin
            load_tree(4'(x));
            data = '1;
            expect_now(1, model_tree(4'(x), '1), "R8");
            data = 10'h2A5;
            expect_now(1, model_tree(4'(x), 10'h2A5), "R8");
        end

        // R1: reset mid-run restores the ground selection
        data = '1;
        rst = 1'b1;
        @(posedge clk); #1;
        rst = 1'b0;
        expect_now(0, 1'b0, "R1");
        expect_now(1, 1'b0, "R1");

        @(posedge clk); #1;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule